// File: doc/BRIEF.md
# Serial Ones-Mod-3 Even-Zeros Detector

This block watches a single serial data line and flags the moments when the history of accepted bits meets two conditions at once. The first is that the number of 1s taken so far is a multiple of three. The second is that the number of 0s taken so far is even and not zero. A bit is taken only on cycles where its qualifying strobe is high.

The detector is built from two small state machines that run side by side. One keeps the count of 1s modulo three. The other sorts the count of 0s into three classes: none yet, odd, and even but non-zero. The flag is the AND of the two machines' accept conditions, and the pair behaves exactly like one nine-state machine over the product of their states.

Two versions of the flag are provided:
- A state-based flag that describes the bits already absorbed.
- A look-ahead flag that describes the class the machine will enter once the bit now on the line has been absorbed.

A system that wants the answer in the same cycle as the bit uses the look-ahead flag. A system that wants a clean flop-driven signal uses the state-based flag.

Top module: `serial_mod3_even_zero_det`

## Requirements
- R1: While `rst` is high at a rising clock edge, both trackers return to their starting classes (no 1s modulo three, no 0s seen). Afterwards `hit_moore_o` is 0, and `hit_mealy_o` is 0 while `bit_vld_i` is low.
- R2: After every accepted bit, `hit_moore_o` equals 1 exactly when the accepted 1-count is a multiple of three and the accepted 0-count is even and non-zero. Example accepted (ones, zeros) pairs are (0,2), (3,2), (3,4) and (6,2).
- R3: A history with zero accepted 0s never raises either flag, whatever the number of accepted 1s.
- R4: Accepted 0s move the zeros class from none to odd, from odd to even, and from even back to odd. An accepted 0 taken while `hit_moore_o` is 1 therefore clears it on the next cycle.
- R5: On a cycle with `bit_vld_i` low, the value of `bit_i` has no effect. Neither tracker changes state, so `hit_moore_o` holds its value.
- R6: While `bit_vld_i` is high, `hit_mealy_o` equals the value `hit_moore_o` will take after the coming clock edge. While `bit_vld_i` is low, `hit_mealy_o` equals `hit_moore_o`.
- R7: An accepted 1 taken while `hit_moore_o` is 1 clears `hit_moore_o` on the next cycle.
- R8: A reset in the middle of a stream discards all history. Counting starts again from zero 1s and zero 0s.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| bit_vld_i | input | 1 | High when `bit_i` carries a bit to be counted |
| bit_i | input | 1 | Serial data bit |
| hit_moore_o | output | 1 | Flag decoded from the present state of both trackers |
| hit_mealy_o | output | 1 | Flag for the state reached after the current bit |

## Verification
The bench first targets histories that have no 0s at all, where three or six 1s must still leave the flag low. A zeros tracker that merged "none" with "even" would raise the flag at reset or after 1s alone. Streams with long runs of 0s check that the zeros class swings between odd and even and never falls back to the empty class, which a wrong wrap would do by dropping acceptance at four or six 0s. Idle cycles with a toggling data line catch a design that counts unqualified bits, and a reset in the middle of a stream catches stale counts. The look-ahead flag is compared before every edge against the counts the bench predicts after the bit, which exposes a look-ahead flag that lags by one bit.

// File: rtl/mod3ev_pkg.sv
package mod3ev_pkg;

  localparam int CLS_W = 2;

  // Residue class of the accepted 1-count; code 2'b11 is unused.
  typedef enum logic [CLS_W-1:0] {
    ONES_R0 = 2'b00,
    ONES_R1 = 2'b01,
    ONES_R2 = 2'b10
  } ones_cls_t;

  // Class of the accepted 0-count; code 2'b11 is unused.
  typedef enum logic [CLS_W-1:0] {
    ZERO_NONE = 2'b00,
    ZERO_ODD  = 2'b01,
    ZERO_EVEN = 2'b10
  } zero_cls_t;

endpackage

// File: rtl/ones_mod3_tracker.sv
module ones_mod3_tracker
  import mod3ev_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      step_i,
  output ones_cls_t cls_o,
  output ones_cls_t cls_nxt_o,
  output logic      acc_o,
  output logic      acc_nxt_o
);

  ones_cls_t cls_q;
  ones_cls_t cls_d;

  always_comb begin
    cls_d = cls_q;
    if (step_i) begin
      unique case (cls_q)
        ONES_R0: cls_d = ONES_R1;
        ONES_R1: cls_d = ONES_R2;
        ONES_R2: cls_d = ONES_R0;
        default: cls_d = ONES_R0;
      endcase
    end else if (cls_q != ONES_R0 && cls_q != ONES_R1 && cls_q != ONES_R2) begin
      // An illegal code falls back to the reset class.
      cls_d = ONES_R0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) cls_q <= ONES_R0;
    else     cls_q <= cls_d;
  end

  assign cls_o     = cls_q;
  assign cls_nxt_o = cls_d;
  assign acc_o     = (cls_q == ONES_R0);
  assign acc_nxt_o = (cls_d == ONES_R0);

endmodule

// File: rtl/zeros_class_tracker.sv
module zeros_class_tracker
  import mod3ev_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      step_i,
  output zero_cls_t cls_o,
  output zero_cls_t cls_nxt_o,
  output logic      acc_o,
  output logic      acc_nxt_o
);

  zero_cls_t cls_q;
  zero_cls_t cls_d;

  always_comb begin
    cls_d = cls_q;
    if (step_i) begin
      unique case (cls_q)
        ZERO_NONE: cls_d = ZERO_ODD;
        ZERO_ODD:  cls_d = ZERO_EVEN;
        ZERO_EVEN: cls_d = ZERO_ODD;
        default:   cls_d = ZERO_NONE;
      endcase
    end else if (cls_q != ZERO_NONE && cls_q != ZERO_ODD && cls_q != ZERO_EVEN) begin
      // An illegal code falls back to the reset class.
      cls_d = ZERO_NONE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) cls_q <= ZERO_NONE;
    else     cls_q <= cls_d;
  end

  assign cls_o     = cls_q;
  assign cls_nxt_o = cls_d;
  assign acc_o     = (cls_q == ZERO_EVEN);
  assign acc_nxt_o = (cls_d == ZERO_EVEN);

endmodule

// File: rtl/serial_mod3_even_zero_det.sv
module serial_mod3_even_zero_det
  import mod3ev_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic bit_vld_i,
  input  logic bit_i,
  output logic hit_moore_o,
  output logic hit_mealy_o
);

  logic      one_step;
  logic      zero_step;
  ones_cls_t ones_cls;
  ones_cls_t ones_nxt;
  zero_cls_t zero_cls;
  zero_cls_t zero_nxt;
  logic      ones_acc;
  logic      ones_acc_nxt;
  logic      zero_acc;
  logic      zero_acc_nxt;

  assign one_step  = bit_vld_i &  bit_i;
  assign zero_step = bit_vld_i & ~bit_i;

  ones_mod3_tracker u_ones (
    .clk       (clk),
    .rst       (rst),
    .step_i    (one_step),
    .cls_o     (ones_cls),
    .cls_nxt_o (ones_nxt),
    .acc_o     (ones_acc),
    .acc_nxt_o (ones_acc_nxt)
  );

  zeros_class_tracker u_zeros (
    .clk       (clk),
    .rst       (rst),
    .step_i    (zero_step),
    .cls_o     (zero_cls),
    .cls_nxt_o (zero_nxt),
    .acc_o     (zero_acc),
    .acc_nxt_o (zero_acc_nxt)
  );

  // The state-based flag decodes flops only; the look-ahead flag
  // decodes the next-state logic of both trackers.
  assign hit_moore_o = ones_acc & zero_acc;
  assign hit_mealy_o = ones_acc_nxt & zero_acc_nxt;

endmodule

// File: rtl/serial_mod3_even_zero_det_chk.sv
module serial_mod3_even_zero_det_chk (
  input logic clk,
  input logic rst,
  input logic bit_vld_i,
  input logic bit_i,
  input logic hit_moore_o,
  input logic hit_mealy_o
);

  // R1
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> !hit_moore_o);

  // R5
  p_idle_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !bit_vld_i |=> $stable(hit_moore_o));

  // R6: the look-ahead flag predicts the next state-based flag.
  p_mealy_predict_r6: assert property (@(posedge clk) disable iff (rst)
    bit_vld_i |=> (hit_moore_o == $past(hit_mealy_o)));

  // R6
  p_mealy_idle_r6: assert property (@(posedge clk) disable iff (rst)
    !bit_vld_i |-> (hit_mealy_o == hit_moore_o));

  // R7
  p_one_leaves_r7: assert property (@(posedge clk) disable iff (rst)
    (bit_vld_i && bit_i && hit_moore_o) |=> !hit_moore_o);

  // R4
  p_zero_leaves_r4: assert property (@(posedge clk) disable iff (rst)
    (bit_vld_i && !bit_i && hit_moore_o) |=> !hit_moore_o);

endmodule

bind serial_mod3_even_zero_det serial_mod3_even_zero_det_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .bit_vld_i   (bit_vld_i),
  .bit_i       (bit_i),
  .hit_moore_o (hit_moore_o),
  .hit_mealy_o (hit_mealy_o)
);

// File: tb/serial_mod3_even_zero_det_tb_top.sv
module serial_mod3_even_zero_det_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic vld = 1'b0;
  logic din = 1'b0;
  logic moore;
  logic mealy;

  int total = 0;
  int bad   = 0;
  int n_one = 0;
  int n_zero = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_mod3_even_zero_det dut_i (
    .clk         (clk),
    .rst         (rst),
    .bit_vld_i   (vld),
    .bit_i       (din),
    .hit_moore_o (moore),
    .hit_mealy_o (mealy)
  );

  function automatic logic exp_hit(int ones, int zeros);
    return (ones % 3 == 0) && (zeros != 0) && (zeros % 2 == 0);
  endfunction

  task automatic check(logic act, logic exp, string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0b expected=%0b (ones=%0d zeros=%0d)",
               tag, act, exp, n_one, n_zero);
    end
  endtask

  // One cycle: check the state flag for the history so far, drive the
  // inputs, check the look-ahead flag, then let the edge take the bit.
  task automatic step(logic v, logic b);
    logic la;
    @(negedge clk);
    check(moore, exp_hit(n_one, n_zero), "R2 state flag");
    vld = v;
    din = b;
    #1;
    if (v) la = b ? exp_hit(n_one + 1, n_zero) : exp_hit(n_one, n_zero + 1);
    else   la = exp_hit(n_one, n_zero);
    check(mealy, la, "R6 look-ahead flag");
    if (v) begin
      if (b) n_one++;
      else   n_zero++;
    end
  endtask

  task automatic do_reset(string tag);
    @(negedge clk);
    rst = 1'b1;
    vld = 1'b0;
    @(negedge clk);
    check(moore, 1'b0, tag);
    check(mealy, 1'b0, tag);
    rst = 1'b0;
    n_one = 0;
    n_zero = 0;
  endtask

  initial begin
    int seed;
    seed = $urandom(32'h5eed_0042);
    do_reset("R1 reset state");

    // R3: ones alone never accept.
    for (int i = 0; i < 6; i++) step(1'b1, 1'b1);
    step(1'b0, 1'b0);
    check(moore, 1'b0, "R3 no zeros");

    // (6,2) accepts; further zeros toggle odd/even (R4).
    for (int i = 0; i < 6; i++) step(1'b1, 1'b0);
    step(1'b0, 1'b0);
    check(moore, 1'b1, "R4 six zeros even");

    // R5: idle cycles with a toggling data line.
    for (int i = 0; i < 4; i++) step(1'b0, i[0]);
    check(moore, 1'b1, "R5 idle hold");

    // R7: a 1 leaves the accepting class.
    step(1'b1, 1'b1);
    step(1'b0, 1'b0);
    check(moore, 1'b0, "R7 one clears");

    // R8: reset mid-stream, then (0,2) accepts from scratch.
    do_reset("R8 mid-stream reset");
    step(1'b1, 1'b0);
    step(1'b1, 1'b0);
    step(1'b0, 1'b0);
    check(moore, 1'b1, "R8 restart (0,2)");

    // Random mix of valid and data.
    for (int i = 0; i < 3000; i++)
      step(($urandom % 4) != 0, $urandom % 2);

    step(1'b0, 1'b0);
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int c = 0; c < WATCHDOG; c++) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule